// File: doc/BRIEF.md
# Four-Way Set-Associative Word Cache

This block sits between a 32-bit processor request port and a slower, word-wide backing memory. It holds 256 sets, each with four ways, and every way stores a single 32-bit word with its tag and a valid flag. An incoming address is split into a byte offset, a set index and a tag. The four tags of the selected set are compared at once, and the result goes back to the processor as a hit or miss flag alongside the response.

Read hits are answered from the cache one cycle after acceptance. A read miss issues a word read to backing memory and waits for the returned data. The data is then written into a victim way of the set and passed to the processor. The victim is the lowest-numbered invalid way if the set has one. Otherwise it is the least recently used way. Writes are write-through without allocation: a hit updates the cached copy, and every write is forwarded to memory.

Only one request is in flight at a time. The processor port reports not-ready from the acceptance of any request that needs memory until that request has been answered.

Top module: `cache_ctrl4w`

## Requirements
- R1: After reset every way is invalid, `cpu_req_ready` is 1, and `cpu_rsp_valid` and `mem_req_valid` are 0, so the first access to any address misses.
- R2: Address bits [1:0] are ignored for lookup, bits [9:2] select the set and bits [31:10] are the tag. Memory requests carry the address with bits [1:0] forced to 0.
- R3: A hit needs a tag match on a valid way. A read hit gives `cpu_rsp_valid`=1, `cpu_rsp_hit`=1 and the cached word in the cycle after acceptance, and no memory request is issued.
- R4: A read miss raises `mem_req_valid` with `mem_req_write`=0 in the cycle after acceptance and holds it until `mem_req_ready`. The cycle after `mem_rsp_valid` is seen, it gives `cpu_rsp_valid`=1, `cpu_rsp_hit`=0 and the memory word.
- R5: When the set has an invalid way, a read miss fills the lowest-numbered invalid way.
- R6: When all four ways are valid, a read miss replaces the least recently used way. Every hit (read or write) and every fill makes the touched way the most recently used.
- R7: Two addresses in the same set coexist. Alternating reads of them give two misses and then only hits.
- R8: A write hit updates the cached word and forwards the write to memory (`mem_req_write`=1, same data). Its response has `cpu_rsp_hit`=1 and comes in the cycle after memory accepts the write.
- R9: A write miss leaves the cache unchanged and forwards the write. Its response has `cpu_rsp_hit`=0.
- R10: While a memory request is pending, `cpu_req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request can be accepted this cycle |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Write data |
| cpu_rsp_valid | output | 1 | Response strobe, one cycle |
| cpu_rsp_hit | output | 1 | Lookup result of the answered request |
| cpu_rsp_rdata | output | 32 | Read data (zero for writes) |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = memory write |
| mem_req_addr | output | 32 | Word-aligned memory address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data present |
| mem_rsp_rdata | input | 32 | Memory read data |

## Verification
A fill and the lookup of the next request can land back to back. The refilled entry is written at the clock edge that also registers the miss response, and a new request can be accepted in the very next cycle. That request's lookup must already see the new tag and the updated recency order. The bench provokes this by issuing each request as soon as ready returns, often to the address just filled or to the same set. A behavioural model of valid bits, tags, data and recency order, kept in the bench, judges every hit flag, every returned word and every memory transfer.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MREQ = 2'd1,
    ST_WAIT = 2'd2
  } ctrl_state_t;
endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 22,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [TAG_W-1:0]            look_tag,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        any_hit,
  output logic [WAY_W-1:0]            hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_valid[w] && (way_tag[w] == look_tag);
  end

  assign any_hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  // R3
  always_comb begin
    one_hit_chk : assert ($onehot0(hit_vec) || $isunknown(hit_vec));
  end
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int WAYS = 4,
  parameter int SETS = 256,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  input  logic [WAYS-1:0]  rd_valid,
  output logic [WAY_W-1:0] victim,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic [WAY_W-1:0] upd_way
);
  // age 0 = most recent, WAYS-1 = least recent
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] row_cur [WAYS];
  logic [WAY_W-1:0] row_nxt [WAYS];
  logic             found;

  always_comb begin
    for (int w = 0; w < WAYS; w++) row_cur[w] = age_q[upd_set][w];
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == upd_way)
        row_nxt[w] = '0;
      else if (row_cur[w] < row_cur[upd_way])
        row_nxt[w] = row_cur[w] + 1'b1;
      else
        row_nxt[w] = row_cur[w];
    end
  end

  always_comb begin
    found  = 1'b0;
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !rd_valid[w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[rd_set][w] == WAY_W'(WAYS-1)) victim = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (upd_en) begin
      for (int w = 0; w < WAYS; w++) age_q[upd_set][w] <= row_nxt[w];
    end
  end

  // R6
  mru_after_touch_chk : assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> age_q[$past(upd_set)][$past(upd_way)] == '0);
endmodule

// File: rtl/cache_ctrl4w.sv
module cache_ctrl4w #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 2,
  parameter int WAYS   = 4,
  localparam int SETS  = 1 << IDX_W,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic              cpu_rsp_hit,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);
  import cache_pkg::*;

  ctrl_state_t state_q, state_d;

  logic [ADDR_W-1:0] req_addr_q;
  logic              req_wr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic [WAY_W-1:0]  req_victim_q;
  logic              req_hit_q;

  logic              rsp_valid_d, rsp_hit_d;
  logic [DATA_W-1:0] rsp_data_d;

  logic              valid_q [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [DATA_W-1:0] data_q  [SETS][WAYS];

  logic [IDX_W-1:0]  lk_idx, fill_idx;
  logic [TAG_W-1:0]  lk_tag, fill_tag;
  logic [WAYS-1:0]   row_valid;
  logic [WAYS-1:0][TAG_W-1:0] row_tag;
  logic [WAYS-1:0]   hit_vec;
  logic              lk_hit;
  logic [WAY_W-1:0]  hit_way, victim;

  logic accept, fill_en, wr_hit_en, wr_done, lru_en;
  logic [IDX_W-1:0] lru_set;
  logic [WAY_W-1:0] lru_way;

  assign lk_idx   = cpu_req_addr[OFF_W +: IDX_W];
  assign lk_tag   = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign fill_idx = req_addr_q[OFF_W +: IDX_W];
  assign fill_tag = req_addr_q[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_row
    assign row_valid[w] = valid_q[lk_idx][w];
    assign row_tag[w]   = tag_q[lk_idx][w];
  end

  cache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_match (
    .way_valid (row_valid),
    .way_tag   (row_tag),
    .look_tag  (lk_tag),
    .hit_vec   (hit_vec),
    .any_hit   (lk_hit),
    .hit_way   (hit_way)
  );

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign fill_en       = (state_q == ST_WAIT) && mem_rsp_valid;
  assign wr_hit_en     = accept && cpu_req_write && lk_hit;
  assign wr_done       = (state_q == ST_MREQ) && req_wr_q && mem_req_ready;

  assign lru_en  = (accept && lk_hit) || fill_en;
  assign lru_set = fill_en ? fill_idx : lk_idx;
  assign lru_way = fill_en ? req_victim_q : hit_way;

  cache_lru #(.WAYS(WAYS), .SETS(SETS)) i_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_set   (lk_idx),
    .rd_valid (row_valid),
    .victim   (victim),
    .upd_en   (lru_en),
    .upd_set  (lru_set),
    .upd_way  (lru_way)
  );

  // next state and response
  always_comb begin
    state_d     = state_q;
    rsp_valid_d = 1'b0;
    rsp_hit_d   = 1'b0;
    rsp_data_d  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (cpu_req_write || !lk_hit) begin
            state_d = ST_MREQ;
          end else begin
            rsp_valid_d = 1'b1;
            rsp_hit_d   = 1'b1;
            rsp_data_d  = data_q[lk_idx][hit_way];
          end
        end
      end
      ST_MREQ: begin
        if (mem_req_ready) begin
          if (req_wr_q) begin
            state_d     = ST_IDLE;
            rsp_valid_d = 1'b1;
            rsp_hit_d   = req_hit_q;
          end else begin
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          state_d     = ST_IDLE;
          rsp_valid_d = 1'b1;
          rsp_data_d  = mem_rsp_rdata;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_hit   <= 1'b0;
      cpu_rsp_rdata <= '0;
    end else begin
      state_q       <= state_d;
      cpu_rsp_valid <= rsp_valid_d;
      cpu_rsp_hit   <= rsp_hit_d;
      cpu_rsp_rdata <= rsp_data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_addr_q   <= '0;
      req_wr_q     <= 1'b0;
      req_wdata_q  <= '0;
      req_victim_q <= '0;
      req_hit_q    <= 1'b0;
    end else if (accept) begin
      req_addr_q   <= cpu_req_addr;
      req_wr_q     <= cpu_req_write;
      req_wdata_q  <= cpu_req_wdata;
      req_victim_q <= victim;
      req_hit_q    <= lk_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          valid_q[s][w] <= 1'b0;
    end else if (fill_en) begin
      valid_q[fill_idx][req_victim_q] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx][req_victim_q]  <= fill_tag;
      data_q[fill_idx][req_victim_q] <= mem_rsp_rdata;
    end else if (wr_hit_en) begin
      data_q[lk_idx][hit_way] <= cpu_req_wdata;
    end
  end

  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_req_write = req_wr_q;
  assign mem_req_addr  = {req_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_req_wdata = req_wdata_q;

  // R1
  reset_idle_chk : assert property (@(posedge clk)
    !rst_n |=> cpu_req_ready && !cpu_rsp_valid && !mem_req_valid);
  // R3
  read_hit_rsp_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cpu_req_write && lk_hit) |=> cpu_rsp_valid && cpu_rsp_hit && !mem_req_valid);
  // R4
  read_miss_req_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cpu_req_write && !lk_hit) |=> mem_req_valid && !mem_req_write);
  // R4
  fill_rsp_chk : assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> cpu_rsp_valid && !cpu_rsp_hit && (cpu_rsp_rdata == $past(mem_rsp_rdata)));
  // R8
  write_fwd_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cpu_req_write) |=> mem_req_valid && mem_req_write && (mem_req_wdata == $past(cpu_req_wdata)));
  // R10
  one_outstanding_chk : assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cpu_req_ready);
endmodule

// File: tb/test_cache_ctrl4w.sv
`timescale 1ns/1ps
module test_cache_ctrl4w;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req_valid, cpu_req_write;
  logic [31:0] cpu_req_addr, cpu_req_wdata;
  logic        cpu_req_ready, cpu_rsp_valid, cpu_rsp_hit;
  logic [31:0] cpu_rsp_rdata;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;

  always #2.5 clk = ~clk;

  cache_ctrl4w i_cache_ctrl4w (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_hit(cpu_rsp_hit), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // bench model
  bit          m_v   [256][4];
  logic [21:0] m_t   [256][4];
  logic [31:0] m_d   [256][4];
  int          m_age [256][4];
  logic [31:0] mem_w [int];

  function automatic logic [31:0] mem_rd(logic [31:0] a);
    if (mem_w.exists(int'(a))) return mem_w[int'(a)];
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  function automatic void touch(int s, int w);
    int a = m_age[s][w];
    for (int k = 0; k < 4; k++)
      if (k != w && m_age[s][k] < a) m_age[s][k]++;
    m_age[s][w] = 0;
  endfunction

  task automatic access(bit wr, logic [31:0] addr, logic [31:0] wd);
    int s = int'(addr[9:2]);
    logic [21:0] tg = addr[31:10];
    logic [31:0] al = {addr[31:2], 2'b00};
    int hw = -1;
    int vic = -1;
    bit exp_hit, got_rsp, saw_mem, pend;
    logic [31:0] exp_d;
    for (int w = 0; w < 4; w++) if (m_v[s][w] && m_t[s][w] == tg) hw = w;
    exp_hit = (hw >= 0);
    exp_d = wr ? 32'h0 : (exp_hit ? m_d[s][hw] : mem_rd(al));
    while (!cpu_req_ready) @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = addr; cpu_req_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    got_rsp = 0; saw_mem = 0; pend = 0;
    for (int c = 0; c < 20 && !got_rsp; c++) begin
      mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
      if (cpu_rsp_valid) begin
        got_rsp = 1;
        check(cpu_rsp_hit == exp_hit, "hit flag", 32'(cpu_rsp_hit), 32'(exp_hit));
        if (!wr) check(cpu_rsp_rdata == exp_d, "read data", cpu_rsp_rdata, exp_d);
      end else begin
        if (mem_req_valid) begin
          saw_mem = 1;
          check(!cpu_req_ready, "R10 ready during mem req", 32'(cpu_req_ready), 32'h0);
          check(mem_req_addr == al, "R2 mem addr", mem_req_addr, al);
          check(mem_req_write == wr, "mem write flag", 32'(mem_req_write), 32'(wr));
          if (wr) check(mem_req_wdata == wd, "R8 mem wdata", mem_req_wdata, wd);
          mem_req_ready = 1'b1;
          pend = !wr;
        end else if (pend) begin
          mem_rsp_valid = 1'b1; mem_rsp_rdata = mem_rd(al); pend = 0;
        end
        @(negedge clk);
      end
    end
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
    check(got_rsp, "response seen", 32'(got_rsp), 32'h1);
    check(saw_mem == (wr || !exp_hit), "memory request presence", 32'(saw_mem), 32'(wr || !exp_hit));
    // update the model
    if (wr) begin
      mem_w[int'(al)] = wd;
      if (exp_hit) begin m_d[s][hw] = wd; touch(s, hw); end
    end else if (exp_hit) begin
      touch(s, hw);
    end else begin
      for (int w = 3; w >= 0; w--) if (!m_v[s][w]) vic = w;
      if (vic < 0) for (int w = 0; w < 4; w++) if (m_age[s][w] == 3) vic = w;
      m_v[s][vic] = 1; m_t[s][vic] = tg; m_d[s][vic] = mem_rd(al);
      touch(s, vic);
    end
  endtask

  function automatic logic [31:0] mk(logic [21:0] tg, logic [7:0] s, logic [1:0] b);
    return {tg, s, b};
  endfunction

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    logic [21:0] tag_tab [6];
    for (int s = 0; s < 256; s++)
      for (int w = 0; w < 4; w++) begin m_v[s][w] = 0; m_age[s][w] = w; end
    cpu_req_valid = 0; cpu_req_write = 0; cpu_req_addr = 0; cpu_req_wdata = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_rdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    check(cpu_req_ready == 1'b1, "R1 ready after reset", 32'(cpu_req_ready), 32'h1);
    check(cpu_rsp_valid == 1'b0, "R1 rsp idle", 32'(cpu_rsp_valid), 32'h0);
    check(mem_req_valid == 1'b0, "R1 mem idle", 32'(mem_req_valid), 32'h0);
    access(0, mk(22'h1, 8'd5, 2'b11), 0);            // first access misses
    cur_req = "R2";
    access(0, mk(22'h1, 8'd5, 2'b00), 0);            // byte bits ignored: hit
    access(0, mk(22'h1, 8'd6, 2'b00), 0);            // other set: miss
    cur_req = "R7";
    for (int i = 0; i < 6; i++) access(0, mk(22'h2 + 22'(i % 2), 8'd9, 2'b00), 0);
    cur_req = "R5";
    for (int t = 1; t <= 4; t++) access(0, mk(22'(t), 8'd7, 2'b00), 0);
    cur_req = "R6";
    access(0, mk(22'h1, 8'd7, 2'b00), 0);            // tag1 becomes most recent
    access(0, mk(22'h5, 8'd7, 2'b00), 0);            // evicts tag2
    check(!m_v[7][1] || m_t[7][1] == 22'h5, "R6 model victim", 32'(m_t[7][1]), 32'h5);
    access(0, mk(22'h2, 8'd7, 2'b00), 0);            // expect miss
    access(0, mk(22'h1, 8'd7, 2'b00), 0);
    cur_req = "R8";
    access(1, mk(22'h1, 8'd7, 2'b10), 32'hCAFE_0001);
    access(0, mk(22'h1, 8'd7, 2'b00), 0);            // sees written word
    cur_req = "R9";
    access(1, mk(22'h3F, 8'd7, 2'b00), 32'hBEEF_0002);
    access(0, mk(22'h3F, 8'd7, 2'b00), 0);           // still a miss, gets memory copy
    cur_req = "R3";
    lf = 32'h1ACE_B00C;
    tag_tab[0] = 22'h0; tag_tab[1] = 22'h1; tag_tab[2] = 22'h3FFFFF;
    tag_tab[3] = 22'h155555; tag_tab[4] = 22'h2AAAAA; tag_tab[5] = 22'h7;
    for (int r = 0; r < 3; r++) begin
      logic [7:0] st = (r == 0) ? 8'd0 : ((r == 1) ? 8'd1 : 8'd255);
      for (int i = 0; i < 200; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        access(lf[3:2] == 2'b00, mk(tag_tab[int'(lf[12:8]) % 6], st, lf[17:16]), lf ^ 32'h0F0F_1234);
      end
    end
    cur_req = "R4";
    access(0, mk(22'h3FFFFF, 8'd200, 2'b01), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule